// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block drives the timing side of a flat-panel display. From three configuration words it produces a pixel clock and a one-cycle pixel strobe, horizontal and vertical sync, and a data-enable. It also reports the current pixel column and line inside the visible area. Geometry comes from a horizontal word and a vertical word. The horizontal word gives active pixels, sync width and both porches. The vertical word gives the same quantities counted in lines. A third word holds the pixel clock divider and the output polarity bits.

Each line runs through sync, back porch, visible pixels and front porch. Each frame runs through the same phases, counted in lines. The block starts a frame one cycle after the enable input is seen high. When enable drops, the frame already in progress is still shown in full. The block then stops and gives a one-cycle frame-done pulse, so the upstream logic knows that reprogramming is safe. A one-cycle vsync event marks the first cycle of every frame.

Top module: `lcd_raster_gen`

## Requirements
- R1: Horizontal word fields: [9:0] active pixels minus one, [15:10] hsync width minus one, [23:16] front porch minus one, [31:24] back porch minus one. Each line is hsync, then back porch, then active pixels, then front porch. hsync is active during the sync pixels only.
- R2: Vertical word fields: [9:0] active lines minus one, [15:10] vsync width minus one. The front porch [23:16] and back porch [31:24] are plain line counts, and zero is allowed. Each frame follows the same phase order, counted in lines.
- R3: Config word bits [7:0] give the divider d. While running, pix_ce_o is high for one cycle in every d logic cycles. A frame lasts d × (pixels per line) × (lines per frame) cycles.
- R4: With tft_i=1 the effective d is at least 2. With tft_i=0 it is at least 3. A smaller programmed value runs at that minimum.
- R5: pclk_o is high for the first floor(d/2) cycles of each pixel period and low for the rest. It is low while stopped.
- R6: de_o is high only on active pixels of active lines. While de_o is high, pix_x_o and line_y_o give the zero-based column and line. Otherwise both are 0.
- R7: vsync_evt_o is high for exactly one cycle, the first cycle of each frame, where vsync begins.
- R8: From idle with enable_i high, the first frame begins in the next cycle.
- R9: When enable_i is low during a frame, that frame completes in full and no new frame starts. frame_done_o is high for one cycle, in the cycle after the last pixel period. All strobes are then inactive. frame_done_o never pulses while frames continue.
- R10: A stop request is latched. Raising enable_i again during the finishing frame does not cancel it. If enable_i is high when frame_done_o pulses, a new frame begins in the next cycle.
- R11: Config bit 20 inverts hsync_o, bit 21 inverts vsync_o, bit 22 inverts de_o and bit 23 inverts pclk_o, in idle as well as running. Bits 24 and 25 have no effect.
- R12: While rst_ni is low and after its release, with enable low and all polarity bits clear, every strobe and pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request |
| tft_i | input | 1 | Panel type, 1 = active matrix |
| hcfg_i | input | 32 | Horizontal geometry word |
| vcfg_i | input | 32 | Vertical geometry word |
| pcfg_i | input | 32 | Divider and polarity word |
| pclk_o | output | 1 | Pixel clock |
| pix_ce_o | output | 1 | One-cycle strobe per pixel period |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x_o | output | 10 | Active column |
| line_y_o | output | 10 | Active line |
| vsync_evt_o | output | 1 | Frame-start pulse |
| frame_done_o | output | 1 | Stop-complete pulse |

## Verification
A wrong horizontal or vertical counter shows up at once in the cycle count between two frame-start pulses. It also changes the hsync, vsync and data-enable cycle totals, all within one frame. A divider fault changes the pixel-strobe and pixel-clock-high counts within the first pixel period. A fault in the stop logic either moves the done pulse away from the exact frame boundary or lets a frame-start pulse appear where only the done pulse belongs.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  localparam int ACT_W   = 10;
  localparam int SYNC_W  = 6;
  localparam int PORCH_W = 8;
  localparam int DIV_W   = 8;
  localparam int CNT_W   = ACT_W + 2;
  localparam int SYNC_LSB = ACT_W;
  localparam int FP_LSB   = SYNC_LSB + SYNC_W;
  localparam int BP_LSB   = FP_LSB + PORCH_W;
  localparam int POL_LSB  = 20;
  localparam int POL_USED = 4;
  localparam int POL_HS   = 0;
  localparam int POL_VS   = 1;
  localparam int POL_DE   = 2;
  localparam int POL_PCLK = 3;

  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] sync_len;
    logic [CNT_W-1:0] bp_len;
    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] fp_len;
  } axis_cfg_t;

  function automatic axis_cfg_t decode_axis(input logic [31:0] w, input logic porch_minus1);
    axis_cfg_t c;
    logic [CNT_W-1:0] adj;
    adj        = {{(CNT_W-1){1'b0}}, porch_minus1};
    c.act_len  = CNT_W'(w[ACT_W-1:0]) + CNT_W'(1);
    c.sync_len = CNT_W'(w[SYNC_LSB +: SYNC_W]) + CNT_W'(1);
    c.fp_len   = CNT_W'(w[FP_LSB +: PORCH_W]) + adj;
    c.bp_len   = CNT_W'(w[BP_LSB +: PORCH_W]) + adj;
    return c;
  endfunction
endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div
  import lcd_raster_pkg::*;
#(
  parameter int DW      = DIV_W,
  parameter int MIN_TFT = 2,
  parameter int MIN_PAS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tft_i,
  input  logic [DW-1:0] div_i,
  output logic          ce_o,
  output logic          pclk_o
);
  logic [DW-1:0] floor_v, div_eff, dcnt_q;

  assign floor_v = tft_i ? DW'(MIN_TFT) : DW'(MIN_PAS);
  assign div_eff = (div_i < floor_v) ? floor_v : div_i;
  assign ce_o    = run_i && (dcnt_q >= div_eff - DW'(1));
  assign pclk_o  = run_i && (dcnt_q < (div_eff >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dcnt_q <= '0;
    else if (!run_i || ce_o)    dcnt_q <= '0;
    else                        dcnt_q <= dcnt_q + DW'(1);
  end

  p_ce_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |=> !ce_o);
  p_pclk_low_at_ce_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |-> !pclk_o);
  p_pclk_needs_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_o |-> run_i);
endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr
  import lcd_raster_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  axis_cfg_t        cfg_i,
  output logic             in_sync_o,
  output logic             in_act_o,
  output logic             last_o,
  output logic [CNT_W-1:0] pos_o
);
  logic [CNT_W-1:0] cnt_q, b_sync, b_back, b_act, total;

  assign b_sync = cfg_i.sync_len;
  assign b_back = b_sync + cfg_i.bp_len;
  assign b_act  = b_back + cfg_i.act_len;
  assign total  = b_act + cfg_i.fp_len;

  assign last_o    = cnt_q >= (total - CNT_W'(1));
  assign in_sync_o = cnt_q < b_sync;
  assign in_act_o  = (cnt_q >= b_back) && (cnt_q < b_act);
  assign pos_o     = in_act_o ? (cnt_q - b_back) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end

  // wrap lands on the first sync unit
  p_wrap_to_sync_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && !clr_i) |=> in_sync_o);
  p_sync_act_apart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_act_o |-> !in_sync_o);
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tft_i,
  input  logic [31:0]      hcfg_i,
  input  logic [31:0]      vcfg_i,
  input  logic [31:0]      pcfg_i,
  output logic             pclk_o,
  output logic             pix_ce_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [ACT_W-1:0] pix_x_o,
  output logic [ACT_W-1:0] line_y_o,
  output logic             vsync_evt_o,
  output logic             frame_done_o
);
  run_state_e       state_q;
  logic             run, stop_pend_q, done_q, evt_q, stop_now, frame_end;
  logic             ce, pclk_raw;
  logic             h_sync, h_act, h_last, v_sync, v_act, v_last;
  logic [CNT_W-1:0] h_pos, v_pos;
  logic             hs_raw, vs_raw, de_raw;
  logic [POL_USED-1:0] pol;
  axis_cfg_t        h_cfg, v_cfg;

  assign run   = (state_q == ST_RUN);
  assign h_cfg = decode_axis(hcfg_i, 1'b1);
  assign v_cfg = decode_axis(vcfg_i, 1'b0);
  assign pol   = pcfg_i[POL_LSB +: POL_USED];

  lcd_pix_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tft_i  (tft_i),
    .div_i  (pcfg_i[DIV_W-1:0]),
    .ce_o   (ce),
    .pclk_o (pclk_raw)
  );

  lcd_axis_ctr u_hctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!run),
    .step_i    (ce),
    .cfg_i     (h_cfg),
    .in_sync_o (h_sync),
    .in_act_o  (h_act),
    .last_o    (h_last),
    .pos_o     (h_pos)
  );

  lcd_axis_ctr u_vctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!run),
    .step_i    (ce && h_last),
    .cfg_i     (v_cfg),
    .in_sync_o (v_sync),
    .in_act_o  (v_act),
    .last_o    (v_last),
    .pos_o     (v_pos)
  );

  assign frame_end = run && ce && h_last && v_last;
  assign stop_now  = stop_pend_q || !enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      stop_pend_q <= 1'b0;
      done_q      <= 1'b0;
      evt_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      evt_q  <= 1'b0;
      if (!run) begin
        stop_pend_q <= 1'b0;
        if (enable_i) begin
          state_q <= ST_RUN;
          evt_q   <= 1'b1;
        end
      end else if (frame_end) begin
        stop_pend_q <= 1'b0;
        if (stop_now) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          evt_q <= 1'b1;
        end
      end else if (!enable_i) begin
        stop_pend_q <= 1'b1;
      end
    end
  end

  assign hs_raw = run && h_sync;
  assign vs_raw = run && v_sync;
  assign de_raw = run && h_act && v_act;

  assign hsync_o      = hs_raw ^ pol[POL_HS];
  assign vsync_o      = vs_raw ^ pol[POL_VS];
  assign de_o         = de_raw ^ pol[POL_DE];
  assign pclk_o       = pclk_raw ^ pol[POL_PCLK];
  assign pix_ce_o     = ce;
  assign pix_x_o      = de_raw ? h_pos[ACT_W-1:0] : '0;
  assign line_y_o     = de_raw ? v_pos[ACT_W-1:0] : '0;
  assign vsync_evt_o  = evt_q;
  assign frame_done_o = done_q;

  logic unused_bits;
  assign unused_bits = ^{pcfg_i[31:POL_LSB+POL_USED], pcfg_i[POL_LSB-1:DIV_W],
                         h_pos[CNT_W-1:ACT_W], v_pos[CNT_W-1:ACT_W]};

  p_done_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  p_done_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !run);
  p_done_after_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_done_o) |-> $past(frame_end));
  p_evt_at_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_evt_o |-> (run && v_sync && h_sync));
  p_de_outside_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_raw |-> (!h_sync && !v_sync));
  p_stop_latched_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !enable_i && !frame_end) |=> stop_pend_q);
endmodule

// File: tb/lcd_raster_gen_bench.sv
`timescale 1ns/1ps
module lcd_raster_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        tft_i = 1'b1;
  logic [31:0] hcfg_i = '0, vcfg_i = '0, pcfg_i = '0;
  logic        pclk_o, pix_ce_o, hsync_o, vsync_o, de_o, vsync_evt_o, frame_done_o;
  logic [9:0]  pix_x_o, line_y_o;

  always #2.5 clk_i = ~clk_i;

  lcd_raster_gen u_lcd_raster_gen (.*);

  int n_tests = 0;
  int n_fail  = 0;

  // columns: act_pix, hsync, hfp, hbp, act_lines, vsync, vfp, vbp, div, tft
  localparam int NVEC = 4;
  localparam int VEC [NVEC][10] = '{
    '{4, 1, 1, 1, 3, 1, 1, 0, 2, 1},
    '{8, 2, 3, 2, 4, 2, 0, 2, 0, 1},
    '{5, 1, 2, 1, 2, 1, 2, 1, 1, 0},
    '{6, 3, 1, 4, 3, 1, 1, 1, 5, 0}
  };

  function automatic logic [31:0] hword(int ha, int hs, int hf, int hb);
    return {8'(hb - 1), 8'(hf - 1), 6'(hs - 1), 10'(ha - 1)};
  endfunction
  function automatic logic [31:0] vword(int va, int vs, int vf, int vb);
    return {8'(vb), 8'(vf), 6'(vs - 1), 10'(va - 1)};
  endfunction
  function automatic int eff_div(int d, int tft);
    int m;
    m = (tft != 0) ? 2 : 3;
    return (d < m) ? m : d;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int m_cyc, m_hs, m_vs, m_de, m_ce, m_pclk, m_done, m_first_de, m_hs0;
  int m_fx, m_fy, m_lx, m_ly;

  // starts on a negedge where vsync_evt_o is high
  task automatic measure();
    m_cyc = 0; m_hs = 0; m_vs = 0; m_de = 0; m_ce = 0; m_pclk = 0; m_done = 0;
    m_first_de = -1; m_fx = -1; m_fy = -1; m_lx = -1; m_ly = -1;
    m_hs0 = int'(hsync_o);
    do begin
      if (de_o) begin
        if (m_first_de < 0) begin
          m_first_de = m_cyc; m_fx = int'(pix_x_o); m_fy = int'(line_y_o);
        end
        m_lx = int'(pix_x_o); m_ly = int'(line_y_o);
      end
      m_hs   += int'(hsync_o);
      m_vs   += int'(vsync_o);
      m_de   += int'(de_o);
      m_ce   += int'(pix_ce_o);
      m_pclk += int'(pclk_o);
      m_done += int'(frame_done_o);
      m_cyc++;
      @(negedge clk_i);
    end while (!(vsync_evt_o || frame_done_o));
  endtask

  task automatic wait_done();
    while (!frame_done_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    chk("R12 outputs in reset", int'({pclk_o, pix_ce_o, hsync_o, vsync_o, de_o,
        vsync_evt_o, frame_done_o}), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R12 outputs idle after reset", int'({pclk_o, pix_ce_o, hsync_o, vsync_o, de_o,
        vsync_evt_o, frame_done_o, pix_x_o, line_y_o}), 0);

    for (int i = 0; i < NVEC; i++) begin
      int ha, hs, hf, hb, va, vs, vf, vb, d, ht, vt, per;
      ha = VEC[i][0]; hs = VEC[i][1]; hf = VEC[i][2]; hb = VEC[i][3];
      va = VEC[i][4]; vs = VEC[i][5]; vf = VEC[i][6]; vb = VEC[i][7];
      d  = eff_div(VEC[i][8], VEC[i][9]);
      ht = hs + hb + ha + hf;
      vt = vs + vb + va + vf;
      per = d * ht * vt;
      hcfg_i = hword(ha, hs, hf, hb);
      vcfg_i = vword(va, vs, vf, vb);
      pcfg_i = 32'(VEC[i][8]);
      tft_i  = VEC[i][9][0];
      enable_i = 1'b1;
      n = 0;
      do begin @(negedge clk_i); n++; end while (!vsync_evt_o);
      chk("R8 start latency", n, 1);
      measure();
      chk("R3 frame period", m_cyc, per);
      chk("R4 effective divider", m_cyc / (ht * vt), d);
      chk("R3 pixel strobes", m_ce, ht * vt);
      chk("R1 hsync cycles", m_hs, d * hs * vt);
      chk("R1 hsync at line start", m_hs0, 1);
      chk("R2 vsync cycles", m_vs, d * ht * vs);
      chk("R2 first active offset", m_first_de, ((vs + vb) * ht + hs + hb) * d);
      chk("R6 de cycles", m_de, d * ha * va);
      chk("R6 first x", m_fx, 0);
      chk("R6 first y", m_fy, 0);
      chk("R6 last x", m_lx, ha - 1);
      chk("R6 last y", m_ly, va - 1);
      chk("R5 pclk high cycles", m_pclk, (d / 2) * ht * vt);
      chk("R9 no done while running", m_done, 0);
      chk("R7 frame start pulse", int'(vsync_evt_o), 1);
      // graceful stop during second frame
      enable_i = 1'b0;
      measure();
      chk("R9 stop frame length", m_cyc, per);
      chk("R9 stop frame de cycles", m_de, d * ha * va);
      chk("R9 done pulse", int'(frame_done_o), 1);
      chk("R9 no new frame", int'(vsync_evt_o), 0);
      @(negedge clk_i);
      chk("R9 idle after done", int'({frame_done_o, hsync_o, vsync_o, de_o, pclk_o,
          pix_ce_o, vsync_evt_o}), 0);
    end

    // R10: stop latched, re-enable restarts right after done
    hcfg_i = hword(4, 1, 1, 1);
    vcfg_i = vword(3, 1, 1, 0);
    pcfg_i = 32'd2;
    tft_i  = 1'b1;
    enable_i = 1'b1;
    while (!vsync_evt_o) @(negedge clk_i);
    n = 0;
    do begin
      if (n == 5)  enable_i = 1'b0;
      if (n == 10) enable_i = 1'b1;
      n++;
      @(negedge clk_i);
    end while (!(frame_done_o || vsync_evt_o));
    chk("R10 latched stop frame length", n, 70);
    chk("R10 done despite re-enable", int'(frame_done_o), 1);
    @(negedge clk_i);
    chk("R10 restart after done", int'(vsync_evt_o), 1);
    enable_i = 1'b0;
    wait_done();

    // R11: polarity
    pcfg_i = 32'h03F0_0002;
    @(negedge clk_i);
    chk("R11 idle inverted levels", int'({hsync_o, vsync_o, de_o, pclk_o}), 15);
    pcfg_i = 32'h0300_0002;
    @(negedge clk_i);
    chk("R11 bits 24-25 no effect", int'({hsync_o, vsync_o, de_o, pclk_o}), 0);
    pcfg_i = 32'h0010_0002;
    enable_i = 1'b1;
    while (!vsync_evt_o) @(negedge clk_i);
    chk("R11 hsync active low", int'(hsync_o), 0);
    chk("R11 de untouched by hsync bit", int'(de_o), 0);
    enable_i = 1'b0;
    wait_done();
    chk("R11 hsync idle high", int'(hsync_o), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule